// File: doc/BRIEF.md
# Decode-Error Default Target for AXI

This block is the catch-all target that an AXI interconnect routes to when a transaction's address matches no real target. It completes every transaction it is given, on both the read and the write side, so that the requesting manager never waits forever. Every response it returns is the decode-error code.

A read is accepted on the read-address channel. The block then returns the full number of data beats that the length field asked for. Each beat carries its own decode-error response and zero data. The final beat is marked as last. The burst is never cut short. A write is accepted on the write-address channel. The block then takes in every write data beat up to and including the one marked last, and only after that returns a single decode-error response on the write-response channel.

The read side and the write side run independently. Each side holds at most one transaction at a time and refuses a new address until its current transaction is finished. Address, data and strobe fields carry no meaning for this block, so only the handshake, ID, length and last signals reach its ports.

Top module: `axi_decerr_slave`

## Requirements
- R1: A read accepted with length field L returns exactly L+1 beats on the read data channel. rLast is 1 on beat L+1 only (counting from 1), and a length field of 0 yields a single beat that is also last.
- R2: Every read data beat carries rResp = 2'b11 (decode error; the encoding is 00 okay, 01 exclusive okay, 10 target error, 11 decode error), and rData is all zeros.
- R3: Every beat of a read burst carries rId equal to the arId captured at its address handshake.
- R4: arReady is 0 from the cycle after a read-address handshake until the final read beat's handshake has completed. It is 1 whenever no read is in flight.
- R5: After a write-address handshake, wReady stays 1 until the beat with wLast = 1 is accepted. bValid rises only in the cycle after that beat's handshake, and exactly one write response with bResp = 2'b11 is issued per write burst.
- R6: The write response carries bId equal to the awId captured at the write-address handshake.
- R7: awReady is 0 from the cycle after a write-address handshake until the write-response handshake completes. It is 1 whenever no write is in flight.
- R8: While rValid = 1 and rReady = 0, the next cycle still has rValid = 1 with unchanged rId, rLast, rResp and rData. A beat advances only on a completed rValid/rReady handshake.
- R9: While bValid = 1 and bReady = 0, the next cycle still has bValid = 1 with unchanged bId and bResp.
- R10: A synchronous reset (rstN = 0 at a rising edge) clears rValid, bValid and wReady and leaves arReady and awReady at 1, including when it interrupts a burst.
- R11: A read and a write can be in flight at the same time, and each completes without waiting for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| arId | input | ID_W | Read transaction ID |
| arLen | input | LEN_W | Read burst length minus one |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rId | output | ID_W | Read data ID |
| rData | output | DATA_W | Read data, always zero |
| rResp | output | 2 | Read response, always 2'b11 |
| rLast | output | 1 | Final beat of read burst |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| awId | input | ID_W | Write transaction ID |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wLast | input | 1 | Final write data beat |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bId | output | ID_W | Write response ID |
| bResp | output | 2 | Write response, always 2'b11 |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |

## Verification
The hardest case to reach is a reset that arrives while a read burst is stalled in the middle. To get there, the bench holds rReady low after an address handshake and asserts rstN while beats are still owed. It then checks that the channel returns to idle and that the next burst starts fresh from its first beat. Long bursts of 256 beats, with rReady and bReady toggled by a pseudo-random pattern, exercise the hold rule on every kind of beat. Running a gapped write alongside those reads shows that the two sides do not block each other.

// File: rtl/axi_decerr_pkg.sv
package axi_decerr_pkg;

  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [0:0] {
    RD_IDLE  = 1'b0,
    RD_BURST = 1'b1
  } rdState_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'b00,
    WR_DATA = 2'b01,
    WR_RESP = 2'b10
  } wrState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic rdCapture;  // latch read ID and length, clear beat count
    logic rdAdvance;  // a non-final read beat was handshaken
    logic wrCapture;  // latch write ID
  } dpStrobe_t;

endpackage

// File: rtl/axi_decerr_ctrl.sv
module axi_decerr_ctrl
  import axi_decerr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      arValid,
  input  logic      rReady,
  input  logic      awValid,
  input  logic      wValid,
  input  logic      wLast,
  input  logic      bReady,
  input  logic      rdFinalBeat,
  output logic      arReady,
  output logic      rValid,
  output logic      awReady,
  output logic      wReady,
  output logic      bValid,
  output dpStrobe_t strobe
);

  rdState_e rdState, rdNext;
  wrState_e wrState, wrNext;

  logic arFire, rFire, awFire, wFire, bFire;

  // Handshake flags, decoded from the registered state
  always_comb begin
    arReady = (rdState == RD_IDLE);
    rValid  = (rdState == RD_BURST);
    awReady = (wrState == WR_IDLE);
    wReady  = (wrState == WR_DATA);
    bValid  = (wrState == WR_RESP);
  end

  assign arFire = arValid & arReady;
  assign rFire  = rValid & rReady;
  assign awFire = awValid & awReady;
  assign wFire  = wValid & wReady;
  assign bFire  = bValid & bReady;

  // Read side
  always_comb begin
    rdNext = rdState;
    unique case (rdState)
      RD_IDLE:  if (arFire) rdNext = RD_BURST;
      RD_BURST: if (rFire && rdFinalBeat) rdNext = RD_IDLE;
      default:  rdNext = RD_IDLE;
    endcase
  end

  // Write side
  always_comb begin
    wrNext = wrState;
    unique case (wrState)
      WR_IDLE: if (awFire) wrNext = WR_DATA;
      WR_DATA: if (wFire && wLast) wrNext = WR_RESP;
      WR_RESP: if (bFire) wrNext = WR_IDLE;
      default: wrNext = WR_IDLE;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.rdCapture = arFire;
    strobe.rdAdvance = rFire & ~rdFinalBeat;
    strobe.wrCapture = awFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdState <= RD_IDLE;
      wrState <= WR_IDLE;
    end else begin
      rdState <= rdNext;
      wrState <= wrNext;
    end
  end

endmodule

// File: rtl/axi_decerr_dp.sv
module axi_decerr_dp
  import axi_decerr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ID_W-1:0]   arId,
  input  logic [LEN_W-1:0]  arLen,
  input  logic [ID_W-1:0]   awId,
  output logic [ID_W-1:0]   rId,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rLast,
  output logic [ID_W-1:0]   bId,
  output logic [1:0]        bResp,
  output logic              rdFinalBeat
);

  logic [ID_W-1:0]  rdIdQ;
  logic [LEN_W-1:0] rdLenQ;
  logic [LEN_W-1:0] rdCntQ;
  logic [ID_W-1:0]  wrIdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdQ  <= '0;
      rdLenQ <= '0;
      rdCntQ <= '0;
    end else if (strobe.rdCapture) begin
      rdIdQ  <= arId;
      rdLenQ <= arLen;
      rdCntQ <= '0;
    end else if (strobe.rdAdvance) begin
      rdCntQ <= rdCntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdQ <= '0;
    end else if (strobe.wrCapture) begin
      wrIdQ <= awId;
    end
  end

  assign rdFinalBeat = (rdCntQ == rdLenQ);
  assign rLast       = rdFinalBeat;
  assign rId         = rdIdQ;
  assign rData       = '0;
  assign rResp       = RESP_DECERR;
  assign bId         = wrIdQ;
  assign bResp       = RESP_DECERR;

endmodule

// File: rtl/axi_decerr_slave.sv
module axi_decerr_slave
  import axi_decerr_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   arId,
  input  logic [LEN_W-1:0]  arLen,
  input  logic              arValid,
  output logic              arReady,
  output logic [ID_W-1:0]   rId,
  output logic [DATA_W-1:0] rData,
  output logic [1:0]        rResp,
  output logic              rLast,
  output logic              rValid,
  input  logic              rReady,
  input  logic [ID_W-1:0]   awId,
  input  logic              awValid,
  output logic              awReady,
  input  logic              wLast,
  input  logic              wValid,
  output logic              wReady,
  output logic [ID_W-1:0]   bId,
  output logic [1:0]        bResp,
  output logic              bValid,
  input  logic              bReady
);

  dpStrobe_t strobe;
  logic      rdFinalBeat;

  axi_decerr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .arValid    (arValid),
    .rReady     (rReady),
    .awValid    (awValid),
    .wValid     (wValid),
    .wLast      (wLast),
    .bReady     (bReady),
    .rdFinalBeat(rdFinalBeat),
    .arReady    (arReady),
    .rValid     (rValid),
    .awReady    (awReady),
    .wReady     (wReady),
    .bValid     (bValid),
    .strobe     (strobe)
  );

  axi_decerr_dp #(
    .ID_W  (ID_W),
    .LEN_W (LEN_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .arId       (arId),
    .arLen      (arLen),
    .awId       (awId),
    .rId        (rId),
    .rData      (rData),
    .rResp      (rResp),
    .rLast      (rLast),
    .bId        (bId),
    .bResp      (bResp),
    .rdFinalBeat(rdFinalBeat)
  );

endmodule

// File: rtl/axi_decerr_chk.sv
module axi_decerr_chk #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ID_W-1:0]   arId,
  input logic [LEN_W-1:0]  arLen,
  input logic              arValid,
  input logic              arReady,
  input logic [ID_W-1:0]   rId,
  input logic [DATA_W-1:0] rData,
  input logic [1:0]        rResp,
  input logic              rLast,
  input logic              rValid,
  input logic              rReady,
  input logic [ID_W-1:0]   awId,
  input logic              awValid,
  input logic              awReady,
  input logic              wLast,
  input logic              wValid,
  input logic              wReady,
  input logic [ID_W-1:0]   bId,
  input logic [1:0]        bResp,
  input logic              bValid,
  input logic              bReady
);

  // Independent beat tracking for the read burst
  logic [LEN_W-1:0] seenLen;
  logic [LEN_W-1:0] seenCnt;
  logic [ID_W-1:0]  seenArId;
  logic [ID_W-1:0]  seenAwId;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenLen  <= '0;
      seenCnt  <= '0;
      seenArId <= '0;
      seenAwId <= '0;
    end else begin
      if (arValid && arReady) begin
        seenLen  <= arLen;
        seenCnt  <= '0;
        seenArId <= arId;
      end else if (rValid && rReady) begin
        seenCnt <= seenCnt + 1'b1;
      end
      if (awValid && awReady) seenAwId <= awId;
    end
  end

  a_r1_last_on_final_beat: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (rLast == (seenCnt == seenLen)));

  a_r2_read_decerr: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (rResp == 2'b11 && rData == '0));

  a_r3_read_id: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> (rId == seenArId));

  a_r4_no_ar_during_burst: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> !arReady);

  a_r5_resp_after_wlast: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bValid) |-> $past(wValid && wReady && wLast));

  a_r5_write_decerr: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> (bResp == 2'b11 && !wReady));

  a_r6_write_id: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> (bId == seenAwId));

  a_r7_no_aw_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (wReady || bValid) |-> !awReady);

  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rId) && $stable(rLast) && $stable(rResp) && $stable(rData)));

  a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> (bValid && $stable(bId) && $stable(bResp)));

  a_r10_reset_idle: assert property (@(posedge clk)
    !rstN |=> (!rValid && !bValid && !wReady && arReady && awReady));

endmodule

bind axi_decerr_slave axi_decerr_chk #(
  .ID_W  (ID_W),
  .LEN_W (LEN_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .arId   (arId),
  .arLen  (arLen),
  .arValid(arValid),
  .arReady(arReady),
  .rId    (rId),
  .rData  (rData),
  .rResp  (rResp),
  .rLast  (rLast),
  .rValid (rValid),
  .rReady (rReady),
  .awId   (awId),
  .awValid(awValid),
  .awReady(awReady),
  .wLast  (wLast),
  .wValid (wValid),
  .wReady (wReady),
  .bId    (bId),
  .bResp  (bResp),
  .bValid (bValid),
  .bReady (bReady)
);

// File: tb/test_axi_decerr_slave.sv
`timescale 1ns/1ps
module test_axi_decerr_slave;
  localparam int ID_W   = 4;
  localparam int LEN_W  = 8;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ID_W-1:0] arId = '0;
  logic [LEN_W-1:0] arLen = '0;
  logic arValid = 1'b0;
  logic arReady;
  logic [ID_W-1:0] rId;
  logic [DATA_W-1:0] rData;
  logic [1:0] rResp;
  logic rLast, rValid;
  logic rReady = 1'b0;
  logic [ID_W-1:0] awId = '0;
  logic awValid = 1'b0;
  logic awReady;
  logic wLast = 1'b0;
  logic wValid = 1'b0;
  logic wReady;
  logic [ID_W-1:0] bId;
  logic [1:0] bResp;
  logic bValid;
  logic bReady = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  axi_decerr_slave #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) i_axi_decerr_slave (
    .clk(clk), .rstN(rstN),
    .arId(arId), .arLen(arLen), .arValid(arValid), .arReady(arReady),
    .rId(rId), .rData(rData), .rResp(rResp), .rLast(rLast), .rValid(rValid), .rReady(rReady),
    .awId(awId), .awValid(awValid), .awReady(awReady),
    .wLast(wLast), .wValid(wValid), .wReady(wReady),
    .bId(bId), .bResp(bResp), .bValid(bValid), .bReady(bReady)
  );

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            last;
  } rExp_t;

  rExp_t rQueue[$];
  logic [ID_W-1:0] bQueue[$];

  int checks = 0;
  int failures = 0;
  int rBeatsSeen = 0;
  int rBeatsExp = 0;
  int bSeen = 0;
  int bExp = 0;

  logic holdR = 1'b0;
  logic rStallEn = 1'b0;
  logic bStallEn = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Read address driver: pushes expected beats into the scoreboard
  task automatic doRead(input logic [ID_W-1:0] id, input logic [LEN_W-1:0] len);
    for (int i = 0; i <= int'(len); i++) begin
      rQueue.push_back('{id: id, last: (i == int'(len))});
      rBeatsExp++;
    end
    @(negedge clk);
    arId = id; arLen = len; arValid = 1'b1;
    while (!arReady) @(negedge clk);
    @(negedge clk);
    arValid = 1'b0;
  endtask

  // Write driver: address, then nBeats of data with optional gaps
  task automatic doWrite(input logic [ID_W-1:0] id, input int nBeats, input logic gaps);
    bQueue.push_back(id);
    bExp++;
    @(negedge clk);
    awId = id; awValid = 1'b1;
    while (!awReady) @(negedge clk);
    @(negedge clk);
    awValid = 1'b0;
    for (int i = 0; i < nBeats; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        @(negedge clk);
      end
      wValid = 1'b1;
      wLast = (i == nBeats - 1);
      while (!wReady) @(negedge clk);
      check(!bValid, "R5 no response before last data", bValid, 0);
      check(!awReady, "R7 awReady low during data", awReady, 0);
      @(negedge clk);
      wValid = 1'b0;
      wLast = 1'b0;
    end
  endtask

  // Read monitor / scoreboard
  logic rPrevStall = 1'b0;
  logic [ID_W-1:0] rIdPrev;
  logic rLastPrev;
  always begin
    @(negedge clk);
    #1;
    if (!rstN) begin
      rPrevStall = 1'b0;
      rReady = 1'b0;
    end else begin
      rReady = holdR ? 1'b0 : (rStallEn ? (lfsr[1] | lfsr[4]) : 1'b1);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (rPrevStall) begin
        check(rValid && rId == rIdPrev && rLast == rLastPrev, "R8 read beat held while stalled",
              {rValid, rId, rLast}, {1'b1, rIdPrev, rLastPrev});
      end
      if (rValid) check(!arReady, "R4 arReady low during burst", arReady, 0);
      if (rValid && rReady) begin
        rBeatsSeen++;
        if (rQueue.size() == 0) begin
          check(1'b0, "R1 unexpected extra read beat", rBeatsSeen, rBeatsExp);
        end else begin
          rExp_t e;
          e = rQueue.pop_front();
          check(rLast == e.last, "R1 rLast position", rLast, e.last);
          check(rResp == 2'b11, "R2 rResp decode error", rResp, 3);
          check(rData == '0, "R2 rData zero", rData, 0);
          check(rId == e.id, "R3 rId matches arId", rId, e.id);
        end
      end
      rPrevStall = rValid && !rReady;
      rIdPrev = rId;
      rLastPrev = rLast;
    end
  end

  // Write response monitor / scoreboard
  logic bPrevStall = 1'b0;
  logic [ID_W-1:0] bIdPrev;
  always begin
    @(negedge clk);
    #1;
    if (!rstN) begin
      bPrevStall = 1'b0;
      bReady = 1'b0;
    end else begin
      bReady = bStallEn ? (lfsr[2] & lfsr[6]) : 1'b1;
      if (bPrevStall)
        check(bValid && bId == bIdPrev, "R9 response held while stalled", {bValid, bId}, {1'b1, bIdPrev});
      if (bValid) check(!awReady, "R7 awReady low until response done", awReady, 0);
      if (bValid && bReady) begin
        bSeen++;
        if (bQueue.size() == 0) begin
          check(1'b0, "R5 extra write response", bSeen, bExp);
        end else begin
          logic [ID_W-1:0] e;
          e = bQueue.pop_front();
          check(bResp == 2'b11, "R5 bResp decode error", bResp, 3);
          check(bId == e, "R6 bId matches awId", bId, e);
        end
      end
      bPrevStall = bValid && !bReady;
      bIdPrev = bId;
    end
  end

  task automatic drain(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (rQueue.size() == 0 && bQueue.size() == 0 && !rValid && !bValid) break;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(arReady && awReady, "R10 ready flags after reset", {arReady, awReady}, 2'b11);
    check(!rValid && !bValid && !wReady, "R10 valid flags clear after reset", {rValid, bValid, wReady}, 0);

    // R1 single-beat read, then short and max bursts
    doRead(4'h3, 8'd0);
    drain(100);
    doRead(4'h5, 8'd3);
    drain(100);
    rStallEn = 1'b1;
    bStallEn = 1'b1;
    doRead(4'hA, 8'd7);
    drain(500);
    doRead(4'hF, 8'd255);
    drain(2000);

    // R5/R6 writes: single beat and gapped multi-beat
    doWrite(4'h1, 1, 1'b0);
    drain(100);
    doWrite(4'h9, 16, 1'b1);
    drain(200);

    // R11 concurrent read and write
    fork
      doRead(4'h6, 8'd15);
      doWrite(4'hC, 6, 1'b1);
    join
    drain(1000);
    check(rBeatsSeen == rBeatsExp, "R1 total read beats", rBeatsSeen, rBeatsExp);
    check(bSeen == bExp, "R5 one response per write", bSeen, bExp);

    // R10 reset in the middle of a stalled read
    holdR = 1'b1;
    doRead(4'h2, 8'd5);
    repeat (3) @(negedge clk);
    check(rValid && !arReady, "R4 stalled burst keeps arReady low", {rValid, arReady}, 2'b10);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rBeatsExp = rBeatsExp - rQueue.size();
    rQueue.delete();
    holdR = 1'b0;
    @(negedge clk);
    check(!rValid && arReady, "R10 reset aborts burst", {rValid, arReady}, 2'b01);

    // After reset a new burst starts from its first beat
    rStallEn = 1'b0;
    doRead(4'h7, 8'd2);
    drain(100);
    check(rQueue.size() == 0 && bQueue.size() == 0, "R1 scoreboard empty", rQueue.size() + bQueue.size(), 0);
    check(rBeatsSeen == rBeatsExp, "R1 final beat count", rBeatsSeen, rBeatsExp);
    finishRun();
  end

endmodule